// File: doc/BRIEF.md
# Cascaded Prescaled Interval Timer

This block is one interval timer of a small timer group. Each clock cycle the surrounding logic may present an advance amount on a valid/ready input stream. The amount is added to a prescale accumulator. Each time the accumulator reaches its period, the period is taken off and a phase bit toggles. The phase bit passes through a gate formed by two group-wide control bits, giving a tick line.

Every falling edge of the tick line, while the timer is enabled, steps an 8-bit divider. When the divider's next value equals the programmed target, the divider returns to zero and a 4-bit event counter increments. Software reads the event counter and clears it with a read-clear strobe.

The gate is evaluated on every cycle. A change to a group control bit while the phase bit is high therefore produces a falling edge of its own, just as a toggle does. The prescale period is a parameter, so slow and fast timers are the same module with a different setting. The stream never applies back-pressure: `adv_ready` is held high and every cycle with `adv_valid` high is one accepted advance.

Top module: `cascade_timer`

## Requirements
- R1: On a cycle with `adv_valid` high, the accumulator adds `adv_amt`. If the sum is at least `PERIOD`, `PERIOD` is subtracted and the phase bit toggles. At most one toggle happens per advance, and `adv_amt` must stay below `PERIOD`.
- R2: If the sum stays below `PERIOD`, or `adv_valid` is low, the phase bit does not change and no count results.
- R3: The tick line equals the phase bit when `grp_run` is 1 and `grp_halt` is 0; otherwise it is 0. While the line is forced low, phase toggles produce no count.
- R4: The divider steps once in the same clock edge as each 1-to-0 transition of the tick line. This includes transitions caused by `grp_run` falling or `grp_halt` rising while the phase bit is 1.
- R5: While `tmr_en` is 0, falling edges of the tick line do not step the divider, and `count` holds.
- R6: When the stepped divider value equals `target`, the divider returns to 0 and `count` increments. The 4-bit `count` wraps from 15 to 0.
- R7: The divider is 8 bits and wraps, so a `target` of 0 gives one count every 256 falling edges.
- R8: A `rd_clr` pulse sets `count` to 0 at the next edge. If an increment falls in the same cycle as `rd_clr`, `count` becomes 1.
- R9: A 0-to-1 change of `tmr_en` clears both the divider and `count` at that edge. A falling edge in that same cycle is dropped.
- R10: `adv_ready` is 1 at all times, including during reset. An advance is taken on every cycle `adv_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_valid | input | 1 | Advance amount present this cycle |
| adv_ready | output | 1 | Always 1; the stream is never stalled |
| adv_amt | input | AMT_W | Advance amount added to the prescaler |
| grp_run | input | 1 | Group enable; 0 forces the tick line low |
| grp_halt | input | 1 | Group stop; 1 forces the tick line low |
| tmr_en | input | 1 | Per-timer enable; a rising change clears the timer |
| target | input | DIV_W | Divider target; 0 means 256 |
| rd_clr | input | 1 | Clear the event counter |
| count | output | CNT_W | Event counter value |

## Verification
Two events can land in the same cycle. An event-counter increment can coincide with a read-clear. An enable rising edge can coincide with a tick-line fall. The first case is set up by raising the phase bit and then dropping `grp_run` in the same cycle as `rd_clr`; the count must then read 1, not 0 or a stepped value. The second case is checked indirectly. The enable is toggled between falls, and the divider must restart from zero: one fall gives no count and the second gives exactly one.

// File: rtl/cascade_timer_pkg.sv
package cascade_timer_pkg;
  localparam int DIV_W_DEF = 8;
  localparam int CNT_W_DEF = 4;

  // Bit width needed to hold a prescale sum before the period is removed.
  function automatic int sum_width(input int period, input int amt_w);
    return $clog2(period + (1 << amt_w));
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PERIOD = 128,
  parameter int AMT_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_valid,
  input  logic [AMT_W-1:0] adv_amt,
  output logic             phase_q,
  output logic             phase_d
);
  import cascade_timer_pkg::*;
  localparam int S0_W = sum_width(PERIOD, AMT_W);

  logic [S0_W-1:0] acc_q, acc_d, sum;
  logic            wrap;

  always_comb begin
    sum     = acc_q + S0_W'(adv_amt);
    wrap    = adv_valid && (sum >= S0_W'(PERIOD));
    acc_d   = acc_q;
    phase_d = phase_q;
    if (adv_valid) begin
      acc_d = wrap ? (sum - S0_W'(PERIOD)) : sum;
      if (wrap) phase_d = ~phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      phase_q <= phase_d;
    end
  end

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_valid |=> ($stable(phase_q) && $stable(acc_q)));

  // R1
  phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_valid && ((acc_q + S0_W'(adv_amt)) >= S0_W'(PERIOD))) |=> (phase_q != $past(phase_q)));
endmodule

// File: rtl/tmr_line_edge.sv
module tmr_line_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic phase_d,
  input  logic grp_run,
  input  logic grp_halt,
  output logic fall
);
  logic line_q, line_d;

  assign line_d = phase_d & grp_run & ~grp_halt;
  assign fall   = line_q & ~line_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_d;
  end

  // R3
  line_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!grp_run || grp_halt) |=> !line_q);

  // R4
  fall_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !line_q);
endmodule

// File: rtl/tmr_divider.sv
module tmr_divider #(
  parameter int DIV_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall,
  input  logic             tmr_en,
  input  logic [DIV_W-1:0] target,
  input  logic             rd_clr,
  output logic [CNT_W-1:0] count
);
  logic             en_q, en_rise, step, hit;
  logic [DIV_W-1:0] div_q, div_inc;

  assign en_rise = tmr_en & ~en_q;
  assign step    = fall & tmr_en & ~en_rise;
  assign div_inc = div_q + 1'b1;
  assign hit     = step && (div_inc == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      div_q <= '0;
      count <= '0;
    end else begin
      en_q <= tmr_en;
      if (en_rise)   div_q <= '0;
      else if (step) div_q <= hit ? '0 : div_inc;
      if (en_rise)     count <= '0;
      else if (rd_clr) count <= hit ? CNT_W'(1) : '0;
      else if (hit)    count <= count + 1'b1;
    end
  end

  // R5
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |=> $stable(div_q));

  // R8
  rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !en_rise) |=> (count <= CNT_W'(1)));

  // R6
  count_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && !rd_clr && !en_rise) |=> $stable(count));

  // R9
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (count == '0 && div_q == '0));
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer #(
  parameter int PERIOD = 128,
  parameter int AMT_W  = 5,
  parameter int DIV_W  = cascade_timer_pkg::DIV_W_DEF,
  parameter int CNT_W  = cascade_timer_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_valid,
  output logic             adv_ready,
  input  logic [AMT_W-1:0] adv_amt,
  input  logic             grp_run,
  input  logic             grp_halt,
  input  logic             tmr_en,
  input  logic [DIV_W-1:0] target,
  input  logic             rd_clr,
  output logic [CNT_W-1:0] count
);
  logic phase_q, phase_d, fall;

  assign adv_ready = 1'b1;

  tmr_prescale #(.PERIOD(PERIOD), .AMT_W(AMT_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .adv_valid(adv_valid), .adv_amt(adv_amt),
    .phase_q(phase_q), .phase_d(phase_d)
  );

  tmr_line_edge u_edge (
    .clk(clk), .rst_n(rst_n), .phase_d(phase_d),
    .grp_run(grp_run), .grp_halt(grp_halt), .fall(fall)
  );

  tmr_divider #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .fall(fall), .tmr_en(tmr_en),
    .target(target), .rd_clr(rd_clr), .count(count)
  );

  // R10
  ready_high_chk: assert property (@(posedge clk) adv_ready);
endmodule

// File: tb/cascade_timer_bench.sv
module cascade_timer_bench;
  localparam int PERIOD = 16;
  localparam int AMT_W  = 4;
  localparam int NV     = 6;
  localparam int V_AMT [NV] = '{8, 15, 1, 4, 12, 0};
  localparam int V_N   [NV] = '{32, 64, 160, 100, 200, 50};
  localparam int V_TGT [NV] = '{2, 3, 5, 4, 1, 1};
  localparam int V_EXP [NV] = '{4, 10, 1, 3, 11, 0};

  logic clk = 0, rst_n = 0;
  logic adv_valid = 0, grp_run = 1, grp_halt = 0, tmr_en = 1, rd_clr = 0;
  logic [AMT_W-1:0] adv_amt = '0;
  logic [7:0] target = 8'd1;
  logic adv_ready;
  logic [3:0] count;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cascade_timer #(.PERIOD(PERIOD), .AMT_W(AMT_W)) u_cascade_timer (
    .clk(clk), .rst_n(rst_n), .adv_valid(adv_valid), .adv_ready(adv_ready),
    .adv_amt(adv_amt), .grp_run(grp_run), .grp_halt(grp_halt), .tmr_en(tmr_en),
    .target(target), .rd_clr(rd_clr), .count(count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic advance(input int amt, input int n);
    adv_amt = AMT_W'(amt);
    adv_valid = 1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    adv_valid = 0;
    adv_amt = '0;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R10 ready in reset", adv_ready, 1);
    rst_n = 1;
    @(negedge clk);
    chk("R8 reset count", count, 0);
    chk("R10 ready", adv_ready, 1);

    // Table: R1 R2 R6 accumulation, divide and wrap
    for (int i = 0; i < NV; i++) begin
      target = 8'(V_TGT[i]);
      do_reset();
      advance(V_AMT[i], V_N[i]);
      chk($sformatf("R1 R2 R6 vector %0d", i), count, V_EXP[i]);
    end

    // Gating and control-created edges
    target = 8'd1;
    do_reset();
    advance(8, 2);
    chk("R2 phase high no count", count, 0);
    grp_run = 0; @(negedge clk);
    chk("R4 run drop edge", count, 1);
    grp_run = 1; @(negedge clk);
    chk("R4 rising line no count", count, 1);
    grp_halt = 1; @(negedge clk);
    chk("R4 halt edge", count, 2);
    advance(8, 4);
    chk("R3 halted toggles", count, 2);
    grp_halt = 0; @(negedge clk);
    advance(8, 2);
    chk("R4 toggle edge", count, 3);

    // R8 read-clear and coincident increment
    advance(8, 2);
    grp_run = 0; rd_clr = 1; @(negedge clk);
    rd_clr = 0; grp_run = 1;
    chk("R8 clear with increment", count, 1);
    rd_clr = 1; @(negedge clk);
    rd_clr = 0;
    chk("R8 plain clear", count, 0);

    // R5 disabled timer, R9 enable rise
    @(negedge clk);
    advance(8, 4);
    chk("R5 enabled count", count, 1);
    tmr_en = 0; @(negedge clk);
    advance(8, 8);
    chk("R5 disabled holds", count, 1);
    tmr_en = 1; @(negedge clk);
    chk("R9 count cleared", count, 0);
    target = 8'd2;
    advance(8, 2);
    tmr_en = 0; @(negedge clk);
    tmr_en = 1; @(negedge clk);
    advance(8, 4);
    chk("R9 divider cleared one edge", count, 0);
    advance(8, 4);
    chk("R9 divider cleared two edges", count, 1);

    // R7 target zero means 256 edges
    target = 8'd0;
    do_reset();
    advance(8, 1020);
    chk("R7 255 edges", count, 0);
    advance(8, 4);
    chk("R7 256 edges", count, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule